// File: doc/BRIEF.md
# Dual-Path Interrupt Request Router

This block gathers the event flags of ten peripherals plus one software-raised flag and presents them to a processor on two request lines: an ordinary interrupt line (`irqReq`) and a fast interrupt line (`fiqReq`). A single latched flag vector is shared by both paths. Each path then applies its own enable mask, so software decides per source which line, if either, it drives. A flag is latched when its peripheral pulses `evtSet`. It is dropped only when the same peripheral pulses `evtClr`. Nothing written over the register bus can remove it.

Software reaches nine registers through a simple word-addressed bus. The bus has a 4-bit address, a write strobe and 32-bit write data, and read data is combinational from the address. Each path offers four registers:
- a flag view;
- a set-style enable register;
- a clear-style enable register;
- a masked status register.

A ninth register holds a programmable source number and the control bit for the software flag. The fast path also has an aggregate bit 0 that is the OR of every source.

Top module: `irq_fiq_router`

## Requirements
- R1: After reset both enable masks, all peripheral flags, the software flag and the source number are zero, and `irqReq` and `fiqReq` are low.
- R2: Peripheral input `k` (0 to 9) owns flag bit `k+2`. A high `evtSet[k]` at a clock edge sets the flag. The flag then holds until a high `evtClr[k]` at a clock edge with `evtSet[k]` low. Set wins when both are high. The flags read at offset 0 (normal) and offset 4 (fast).
- R3: A write to offset 1 (normal) or offset 5 (fast) sets each enable whose data bit is 1 and leaves the others unchanged. Reading the same offset returns the enable mask.
- R4: A write to offset 2 (normal) or offset 6 (fast) clears each enable whose data bit is 1. These offsets read as zero.
- R5: Status at offset 3 (normal) and offset 7 (fast) has bit `n` (2 to 11) high exactly when flag `n` is set and enable `n` of that path is set.
- R6: `irqReq` is the OR of normal status bits 1 to 11, and `fiqReq` is the OR of fast status bits 1 to 11. Each follows one clock edge after the flag or enable change that causes it.
- R7: Offset 8 bit 16 is the software flag and appears as bit 1 of both flag views. Enable bit 1 cannot be set or cleared and reads 0. Software status bit 1 equals the software flag in both paths, so it raises both lines.
- R8: Bit 0 exists only in the fast path. In the fast flag view it is the OR of flags 1 to 11, and in fast status it is the OR of fast status bits 1 to 11. Bit 0 reads 0 in every other register and cannot be enabled.
- R9: Bits 12 to 31 of offsets 0 to 7 read zero and ignore writes. Offsets 9 to 15 read zero.
- R10: Offset 8 bits 3:0 store a written source number and read it back with bit 16. All other bits of offset 8 read zero.
- R11: Writes to the flag-view and status offsets (0, 3, 4, 7) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtSet | input | 10 | Per-peripheral flag set pulse |
| evtClr | input | 10 | Per-peripheral flag clear pulse |
| busAddr | input | 4 | Word register offset |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr` |
| irqReq | output | 1 | Normal interrupt request |
| fiqReq | output | 1 | Fast interrupt request |

## Verification
The bench sweeps many computed pairs of enable masks against flag patterns. A design that mixed up the two masks, or shifted the source-to-bit mapping by one, shows a wrong status word or a wrong request line. Bit 1 is checked in several places:
- Enable writes of all ones must read back without bits 0 and 1.
- The software flag must raise both lines with no enables set.

An aggregate bit 0 that leaks into the normal registers shows up the same way. The bench also writes over the flag and status offsets, and it drives set and clear together. A controller that clears flags from the bus, or lets clear win, loses a latched flag. A request line that is combinational rather than registered is caught by sampling between the causing edge and the next one.

// File: rtl/irq_fiq_pkg.sv
package irq_fiq_pkg;

  localparam int ADDR_W = 4;

  // register offsets (word addresses)
  localparam logic [ADDR_W-1:0] OFF_IRQ_RAW  = 4'd0;
  localparam logic [ADDR_W-1:0] OFF_IRQ_EN   = 4'd1;
  localparam logic [ADDR_W-1:0] OFF_IRQ_CLR  = 4'd2;
  localparam logic [ADDR_W-1:0] OFF_IRQ_STAT = 4'd3;
  localparam logic [ADDR_W-1:0] OFF_FIQ_RAW  = 4'd4;
  localparam logic [ADDR_W-1:0] OFF_FIQ_EN   = 4'd5;
  localparam logic [ADDR_W-1:0] OFF_FIQ_CLR  = 4'd6;
  localparam logic [ADDR_W-1:0] OFF_FIQ_STAT = 4'd7;
  localparam logic [ADDR_W-1:0] OFF_SEL      = 4'd8;

  // write strobes from the decoder into the datapath
  typedef struct packed {
    logic irqSet;
    logic irqClr;
    logic fiqSet;
    logic fiqClr;
    logic selWr;
  } wrStrobe_t;

  typedef enum logic [3:0] {
    RD_IRQ_RAW  = 4'd0,
    RD_IRQ_EN   = 4'd1,
    RD_IRQ_STAT = 4'd2,
    RD_FIQ_RAW  = 4'd3,
    RD_FIQ_EN   = 4'd4,
    RD_FIQ_STAT = 4'd5,
    RD_SEL      = 4'd6,
    RD_ZERO     = 4'd7
  } rdSel_e;

endpackage

// File: rtl/irq_fiq_decode.sv
module irq_fiq_decode
  import irq_fiq_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output wrStrobe_t         strobes,
  output rdSel_e            rdSel
);

  always_comb begin
    strobes = '0;
    rdSel   = RD_ZERO;
    unique case (busAddr)
      OFF_IRQ_RAW:  rdSel = RD_IRQ_RAW;
      OFF_IRQ_EN: begin
        rdSel          = RD_IRQ_EN;
        strobes.irqSet = busWrEn;
      end
      OFF_IRQ_CLR:  strobes.irqClr = busWrEn;
      OFF_IRQ_STAT: rdSel = RD_IRQ_STAT;
      OFF_FIQ_RAW:  rdSel = RD_FIQ_RAW;
      OFF_FIQ_EN: begin
        rdSel          = RD_FIQ_EN;
        strobes.fiqSet = busWrEn;
      end
      OFF_FIQ_CLR:  strobes.fiqClr = busWrEn;
      OFF_FIQ_STAT: rdSel = RD_FIQ_STAT;
      OFF_SEL: begin
        rdSel         = RD_SEL;
        strobes.selWr = busWrEn;
      end
      default:      rdSel = RD_ZERO;
    endcase
  end

endmodule

// File: rtl/irq_fiq_datapath.sv
module irq_fiq_datapath
  import irq_fiq_pkg::*;
#(
  parameter int NUM_HW  = 10,
  parameter int DATA_W  = 32,
  parameter int SEL_W   = 4,
  parameter int SWI_POS = 16,
  localparam int FIRST_HW = 2,
  localparam int VEC_W    = FIRST_HW + NUM_HW
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_HW-1:0] evtSet,
  input  logic [NUM_HW-1:0] evtClr,
  input  wrStrobe_t         strobes,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqReq,
  output logic              fiqReq,
  output logic [VEC_W-1:0]  rawVec,
  output logic [VEC_W-1:0]  irqStat,
  output logic [VEC_W-1:0]  fiqStat
);

  // maskable bits are the peripheral bits only; bit 1 is the software flag
  localparam logic [VEC_W-1:0] EN_MASK = {{NUM_HW{1'b1}}, 2'b00};
  localparam logic [VEC_W-1:0] SWI_BIT = VEC_W'(2);

  logic [NUM_HW-1:0] hwRaw;
  logic              swiReg;
  logic [SEL_W-1:0]  selReg;

  // peripheral flags: set wins over clear, bus never touches them
  for (genvar g = 0; g < NUM_HW; g++) begin : gRaw
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           hwRaw[g] <= 1'b0;
      else if (evtSet[g])  hwRaw[g] <= 1'b1;
      else if (evtClr[g])  hwRaw[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
      swiReg <= 1'b0;
    end else if (strobes.selWr) begin
      selReg <= wrData[SEL_W-1:0];
      swiReg <= wrData[SWI_POS];
    end
  end

  assign rawVec = {hwRaw, swiReg, 1'b0};

  // per-path enable masks and status (path 0 normal, path 1 fast)
  logic [1:0]       setStb;
  logic [1:0]       clrStb;
  logic [VEC_W-1:0] enArr   [2];
  logic [VEC_W-1:0] statArr [2];
  logic [1:0]       reqArr;
  logic [VEC_W-1:0] wrBits;

  assign setStb = {strobes.fiqSet, strobes.irqSet};
  assign clrStb = {strobes.fiqClr, strobes.irqClr};
  assign wrBits = wrData[VEC_W-1:0] & EN_MASK;

  for (genvar p = 0; p < 2; p++) begin : gPath
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          enArr[p] <= '0;
      else if (setStb[p]) enArr[p] <= enArr[p] | wrBits;
      else if (clrStb[p]) enArr[p] <= enArr[p] & ~wrBits;
    end

    assign statArr[p] = rawVec & (enArr[p] | SWI_BIT);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) reqArr[p] <= 1'b0;
      else       reqArr[p] <= |statArr[p][VEC_W-1:1];
    end
  end

  assign irqStat = statArr[0];
  assign fiqStat = {statArr[1][VEC_W-1:1], |statArr[1][VEC_W-1:1]};
  assign irqReq  = reqArr[0];
  assign fiqReq  = reqArr[1];

  logic [VEC_W-1:0]  fiqRawView;
  logic [DATA_W-1:0] selView;

  assign fiqRawView = {rawVec[VEC_W-1:1], |rawVec[VEC_W-1:1]};

  always_comb begin
    selView                = '0;
    selView[SEL_W-1:0]     = selReg;
    selView[SWI_POS]       = swiReg;
  end

  always_comb begin
    unique case (rdSel)
      RD_IRQ_RAW:  rdData = DATA_W'(rawVec);
      RD_IRQ_EN:   rdData = DATA_W'(enArr[0]);
      RD_IRQ_STAT: rdData = DATA_W'(irqStat);
      RD_FIQ_RAW:  rdData = DATA_W'(fiqRawView);
      RD_FIQ_EN:   rdData = DATA_W'(enArr[1]);
      RD_FIQ_STAT: rdData = DATA_W'(fiqStat);
      RD_SEL:      rdData = selView;
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_fiq_router.sv
module irq_fiq_router
  import irq_fiq_pkg::*;
#(
  parameter int NUM_HW  = 10,
  parameter int DATA_W  = 32,
  parameter int SEL_W   = 4,
  parameter int SWI_POS = 16,
  localparam int VEC_W  = NUM_HW + 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_HW-1:0] evtSet,
  input  logic [NUM_HW-1:0] evtClr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqReq,
  output logic              fiqReq
);

  wrStrobe_t        strobes;
  rdSel_e           rdSel;
  logic [VEC_W-1:0] rawVec;
  logic [VEC_W-1:0] irqStat;
  logic [VEC_W-1:0] fiqStat;

  irq_fiq_decode u_decode (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  irq_fiq_datapath #(
    .NUM_HW  (NUM_HW),
    .DATA_W  (DATA_W),
    .SEL_W   (SEL_W),
    .SWI_POS (SWI_POS)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .evtSet  (evtSet),
    .evtClr  (evtClr),
    .strobes (strobes),
    .rdSel   (rdSel),
    .wrData  (busWrData),
    .rdData  (busRdData),
    .irqReq  (irqReq),
    .fiqReq  (fiqReq),
    .rawVec  (rawVec),
    .irqStat (irqStat),
    .fiqStat (fiqStat)
  );

endmodule

// File: rtl/irq_fiq_router_chk.sv
module irq_fiq_router_chk
  import irq_fiq_pkg::*;
#(
  parameter int NUM_HW = 10,
  parameter int DATA_W = 32,
  localparam int VEC_W = NUM_HW + 2
)(
  input logic              clk,
  input logic              rstN,
  input logic [NUM_HW-1:0] evtSet,
  input logic [NUM_HW-1:0] evtClr,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic              irqReq,
  input logic              fiqReq,
  input logic [VEC_W-1:0]  rawVec,
  input logic [VEC_W-1:0]  irqStat,
  input logic [VEC_W-1:0]  fiqStat
);

  // R2: a set pulse shows up in the flag vector at the next edge
  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rstN)
    (|evtSet) |=> ((rawVec[VEC_W-1:2] & $past(evtSet)) == $past(evtSet)));

  // R2 / R11: a held flag survives every cycle without its own clear
  a_r2_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawVec[VEC_W-1:2] & $past(rawVec[VEC_W-1:2] & ~evtClr))
              == $past(rawVec[VEC_W-1:2] & ~evtClr)));

  // R5: status never shows a source whose flag is down
  a_r5_stat_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    ((irqStat[VEC_W-1:1] & ~rawVec[VEC_W-1:1]) == '0) &&
    ((fiqStat[VEC_W-1:1] & ~rawVec[VEC_W-1:1]) == '0));

  // R4: after an enable-clear write the cleared sources leave status
  a_r4_clear_masks: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFF_IRQ_CLR) |=>
      ((irqStat[VEC_W-1:2] & $past(busWrData[VEC_W-1:2])) == '0));

  // R6: request lines trail the status one edge
  a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqReq == $past(|irqStat[VEC_W-1:1])));

  a_r6_fiq_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (fiqReq == $past(|fiqStat[VEC_W-1:1])));

  // R9: upper read bits stay zero apart from the software control bit
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRdData[DATA_W-1:17] == '0) && (busRdData[15:VEC_W] == '0));

endmodule

bind irq_fiq_router irq_fiq_router_chk u_chk (.*);

// File: tb/irq_fiq_router_tb.sv
`timescale 1ns/1ps
module irq_fiq_router_tb;

  localparam int NUM_HW = 10;
  localparam logic [11:0] MASK = 12'hFFC;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NUM_HW-1:0] evtSet = '0;
  logic [NUM_HW-1:0] evtClr = '0;
  logic [3:0]        busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic              irqReq;
  logic              fiqReq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // bench model
  logic [11:0] rawM = '0;
  logic [11:0] enI  = '0;
  logic [11:0] enF  = '0;
  logic [3:0]  selM = '0;

  always #2.5 clk = ~clk;

  irq_fiq_router u_dut (
    .clk(clk), .rstN(rstN), .evtSet(evtSet), .evtClr(evtClr),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .irqReq(irqReq), .fiqReq(fiqReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    busAddr = a; #1; v = busRdData;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    settle();
    busWrEn = 1'b0;
    case (a)
      4'd1: enI = enI | (d[11:0] & MASK);
      4'd2: enI = enI & ~(d[11:0] & MASK);
      4'd5: enF = enF | (d[11:0] & MASK);
      4'd6: enF = enF & ~(d[11:0] & MASK);
      4'd8: begin selM = d[3:0]; rawM[1] = d[16]; end
      default: ;
    endcase
  endtask

  task automatic evt(input logic [9:0] s, input logic [9:0] c);
    evtSet = s; evtClr = c;
    settle();
    evtSet = '0; evtClr = '0;
    rawM[11:2] = (rawM[11:2] & ~c) | s;
  endtask

  function automatic logic [11:0] irqS();
    return rawM & (enI | 12'h002);
  endfunction
  function automatic logic [11:0] fiqS();
    logic [11:0] t;
    t = rawM & (enF | 12'h002);
    t[0] = |t[11:1];
    return t;
  endfunction

  // compare every register and both lines against the model
  task automatic checkAll(input string tag);
    logic [31:0] v;
    logic [11:0] fr;
    fr = rawM; fr[0] = |rawM[11:1];
    rd(4'd0, v); check({tag, " R2 irq flags"}, v, {20'd0, rawM});
    rd(4'd4, v); check({tag, " R8 fiq flags"}, v, {20'd0, fr});
    rd(4'd1, v); check({tag, " R3 irq en"}, v, {20'd0, enI});
    rd(4'd5, v); check({tag, " R3 fiq en"}, v, {20'd0, enF});
    rd(4'd3, v); check({tag, " R5 irq stat"}, v, {20'd0, irqS()});
    rd(4'd7, v); check({tag, " R5 fiq stat"}, v, {20'd0, fiqS()});
    settle();
    check({tag, " R6 irqReq"}, {31'd0, irqReq}, {31'd0, |irqS()});
    check({tag, " R6 fiqReq"}, {31'd0, fiqReq}, {31'd0, |fiqS()});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irqReq", {31'd0, irqReq}, 32'd0);
    check("R1 fiqReq", {31'd0, fiqReq}, 32'd0);
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v); check($sformatf("R1 offset %0d", a), v, 32'd0);
    end

    // R3 R7 R8 R9 enable set with all ones
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, v); check("R3 R7 R8 R9 irq en all ones", v, 32'h0000_0FFC);
    wr(4'd1, 32'h0);
    rd(4'd1, v); check("R3 zero write keeps", v, 32'h0000_0FFC);
    wr(4'd2, 32'h0000_00F0);
    rd(4'd1, v); check("R4 partial clear", v, 32'h0000_0F0C);
    rd(4'd2, v); check("R4 clear reads zero", v, 32'd0);
    rd(4'd6, v); check("R4 fiq clear reads zero", v, 32'd0);
    wr(4'd2, 32'hFFFF_FFFF);

    // R10 select register
    wr(4'd8, 32'hFFFE_FFF5);
    rd(4'd8, v); check("R10 select readback", v, 32'h0000_0005);

    // R9 unmapped offsets
    for (int a = 9; a < 16; a++) begin
      rd(4'(a), v); check($sformatf("R9 offset %0d", a), v, 32'd0);
    end

    // R6 latency: line must not move before the edge after the flag edge
    wr(4'd1, 32'h0000_0004);
    evtSet = 10'b1; @(posedge clk); @(negedge clk); evtSet = '0;
    rawM[2] = 1'b1;
    check("R6 irqReq not yet", {31'd0, irqReq}, 32'd0);
    settle();
    check("R6 irqReq after one edge", {31'd0, irqReq}, 32'd1);
    check("R6 fiqReq masked", {31'd0, fiqReq}, 32'd0);

    // R2 set wins over clear; R11 bus writes leave flags alone
    evt(10'b1, 10'b1);
    checkAll("R2 set wins");
    wr(4'd0, 32'hFFFF_FFFF); wr(4'd3, 32'hFFFF_FFFF);
    wr(4'd4, 32'hFFFF_FFFF); wr(4'd7, 32'hFFFF_FFFF);
    checkAll("R11 flag survives bus writes");
    evt(10'd0, 10'b1);
    checkAll("R2 peripheral clear");

    // R7 software flag raises both lines with no enables
    wr(4'd2, 32'hFFF); wr(4'd6, 32'hFFF);
    wr(4'd8, 32'h0001_0003);
    checkAll("R7 swi on");
    rd(4'd8, v); check("R10 R7 select with swi", v, 32'h0001_0003);
    wr(4'd1, 32'h2); wr(4'd6, 32'h2);
    checkAll("R7 swi unmaskable");
    wr(4'd8, 32'h0);
    checkAll("R7 swi off");

    // R5 single-source sweep per path
    for (int s = 0; s < NUM_HW; s++) begin
      wr(4'd2, 32'hFFF); wr(4'd6, 32'hFFF);
      wr((s % 2) ? 4'd5 : 4'd1, 32'(1) << (s + 2));
      evt(10'(1) << s, 10'd0);
      checkAll($sformatf("R5 single src %0d", s));
      evt(10'd0, 10'(1) << s);
      checkAll($sformatf("R2 R6 single src %0d cleared", s));
    end

    // R5 R6 R8 pattern sweep with arithmetic patterns
    for (int p = 0; p < 64; p++) begin
      int ip, fp, rp;
      ip = (p * 37 + 5) % 1024;
      fp = (p * 91 + 3) % 1024;
      rp = (p * 53 + 11) % 1024;
      wr(4'd2, 32'hFFF); wr(4'd6, 32'hFFF);
      evt(10'd0, 10'h3FF);
      wr(4'd1, 32'(ip) << 2);
      wr(4'd5, 32'(fp) << 2);
      evt(10'(rp), 10'd0);
      checkAll($sformatf("R5 sweep %0d", p));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule